// File: doc/BRIEF.md
# Packed Signed-Integer to Double-Precision Converter

This block takes a 64-bit operand holding two signed 32-bit two's-complement integers and turns each into an IEEE-754 double-precision value. The 128-bit result is registered and presented one cycle after a request is accepted. Because every 32-bit integer is exactly representable as a double, the datapath needs no rounding. It takes the magnitude, finds the leading one, biases the exponent and left-justifies the remaining bits into the fraction.

The operand comes from one of two places, chosen per request by an operand-select input: a 64-bit SIMD integer register or a 64-bit memory word. When the register is the source, the conversion also switches the legacy floating-point stack into integer-SIMD use. Alongside the result the block pulses two side-band strobes: one resets the stack-top pointer to zero and one clears the tag word to all-valid. A register-source request that arrives while a legacy floating-point exception is pending is not accepted. The block raises a stall so that the exception is serviced first. The requester holds the request until the pending flag drops. Memory-source requests never touch the stack state and never wait on the pending exception.

Top module: `pkcvt_i2d`

## Requirements
- R1: Each 32-bit lane is converted to the exact double-precision encoding of its signed value: sign in bit 63, an 11-bit biased exponent (bias 1023) in bits 62:52, and a 52-bit fraction in bits 51:0 with the implicit leading one dropped.
- R2: Result bits 63:0 hold the conversion of operand bits 31:0, and result bits 127:64 hold the conversion of operand bits 63:32.
- R3: A lane value of zero yields all 64 bits zero (+0.0).
- R4: A lane value of -2147483648 yields sign 1, biased exponent 1054 and a zero fraction (0xC1E0000000000000).
- R5: A request is accepted when in_valid and in_ready are both high. out_valid is high in exactly the cycle after an accepted request, and out_data then holds that request's result.
- R6: When src_is_reg is 1 on an accepted request, tos_clear and tag_clear are both high for one cycle, in the same cycle as that request's out_valid.
- R7: When src_is_reg is 0 on an accepted request, the operand is taken from mem_src, and tos_clear and tag_clear stay low in the result cycle.
- R8: While in_valid, src_is_reg and fp_exc_pending are all high, stall is 1, in_ready is 0 and no result is produced in the following cycle.
- R9: When src_is_reg is 0, in_ready is 1 and stall is 0 whatever the value of fp_exc_pending.
- R10: A register-source request that is held through a stall completes in the cycle after fp_exc_pending drops, with the result of the held operand.
- R11: After reset, out_valid, out_data, tos_clear and tag_clear are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| src_is_reg | input | 1 | 1 = operand from SIMD integer register, 0 = from memory |
| reg_src | input | 64 | Register operand, two packed signed 32-bit lanes |
| mem_src | input | 64 | Memory operand, two packed signed 32-bit lanes |
| fp_exc_pending | input | 1 | A legacy floating-point exception is waiting to be serviced |
| stall | output | 1 | Register-source request held back for the pending exception |
| out_valid | output | 1 | Result valid |
| out_data | output | 128 | Two double-precision results, low lane in bits 63:0 |
| tos_clear | output | 1 | Reset the legacy stack-top pointer to 0 |
| tag_clear | output | 1 | Write the legacy tag word as all-valid (zeros) |

## Verification
An error in the leading-one position or the normalising shift appears at out_data one cycle after acceptance. It shows as a wrong exponent or a fraction shifted by one or more places, and it is most visible on powers of two, on values near full scale and on -2147483648. A fault in the operand select or the lane order swaps whole 64-bit halves, or takes them from the wrong source, in that same result cycle. A fault in the control path shows up differently: strobes missing, or present on a memory-source result, or a stall that holds for memory requests or lets a register request through under a pending exception. These appear on in_ready and stall in the request cycle, and on out_valid and the strobes one cycle later.

// File: rtl/pkcvt_pkg.sv
package pkcvt_pkg;

    localparam int INT_W  = 32;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int BIAS   = 1023;
    localparam int DBL_W  = 1 + EXP_W + FRAC_W;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } dbl_t;

    typedef struct packed {
        logic        valid;
        logic        from_reg;
    } req_ctl_t;

    function automatic logic [INT_W-1:0] abs_val(input logic [INT_W-1:0] x);
        return x[INT_W-1] ? (~x + INT_W'(1)) : x;
    endfunction

endpackage

// File: rtl/pkcvt_lead_one.sv
module pkcvt_lead_one #(
    parameter int W  = 32,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [PW-1:0] pos,
    output logic          found
);
    always_comb begin
        pos   = '0;
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                pos   = PW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pkcvt_lane.sv
module pkcvt_lane
    import pkcvt_pkg::*;
#(
    parameter int W = INT_W,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0] ival,
    output dbl_t         dval
);
    localparam logic [EXP_W-1:0] BIAS_V = EXP_W'(BIAS);
    localparam int PAD = FRAC_W - (W - 1);

    logic [W-1:0]  mag;
    logic [PW-1:0] msb_pos;
    logic          nonzero;
    logic [PW-1:0] shamt;
    logic [W-1:0]  norm;

    assign mag = abs_val(ival);

    pkcvt_lead_one #(.W(W)) u_lzd (
        .vec   (mag),
        .pos   (msb_pos),
        .found (nonzero)
    );

    assign shamt = PW'(W - 1) - msb_pos;
    assign norm  = mag << shamt;

    always_comb begin
        if (nonzero) begin
            dval.sign = ival[W-1];
            dval.exp  = BIAS_V + EXP_W'(msb_pos);
            dval.frac = {norm[W-2:0], {PAD{1'b0}}};
        end else begin
            dval = '0;
        end
    end
endmodule

// File: rtl/pkcvt_ctrl.sv
module pkcvt_ctrl (
    input  logic in_valid,
    input  logic src_is_reg,
    input  logic fp_exc_pending,
    output logic in_ready,
    output logic stall,
    output logic accept
);
    logic blocked;
    assign blocked  = src_is_reg & fp_exc_pending;
    assign in_ready = ~blocked;
    assign stall    = in_valid & blocked;
    assign accept   = in_valid & ~blocked;
endmodule

// File: rtl/pkcvt_i2d.sv
module pkcvt_i2d
    import pkcvt_pkg::*;
#(
    parameter int LANES = 2,
    localparam int SRC_W = LANES * INT_W,
    localparam int RES_W = LANES * DBL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             src_is_reg,
    input  logic [SRC_W-1:0] reg_src,
    input  logic [SRC_W-1:0] mem_src,
    input  logic             fp_exc_pending,
    output logic             stall,
    output logic             out_valid,
    output logic [RES_W-1:0] out_data,
    output logic             tos_clear,
    output logic             tag_clear
);
    logic             accept;
    logic [SRC_W-1:0] operand;
    logic [RES_W-1:0] conv;
    req_ctl_t         ctl_q;
    logic [RES_W-1:0] data_q;

    pkcvt_ctrl u_ctrl (
        .in_valid       (in_valid),
        .src_is_reg     (src_is_reg),
        .fp_exc_pending (fp_exc_pending),
        .in_ready       (in_ready),
        .stall          (stall),
        .accept         (accept)
    );

    assign operand = src_is_reg ? reg_src : mem_src;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dbl_t lane_res;
        pkcvt_lane #(.W(INT_W)) u_lane (
            .ival (operand[g*INT_W +: INT_W]),
            .dval (lane_res)
        );
        assign conv[g*DBL_W +: DBL_W] = lane_res;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            data_q <= '0;
        end else begin
            ctl_q.valid    <= accept;
            ctl_q.from_reg <= accept & src_is_reg;
            if (accept) data_q <= conv;
        end
    end

    assign out_valid = ctl_q.valid;
    assign out_data  = data_q;
    assign tos_clear = ctl_q.from_reg;
    assign tag_clear = ctl_q.from_reg;
endmodule

// File: rtl/pkcvt_i2d_chk.sv
module pkcvt_i2d_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic src_is_reg,
    input logic fp_exc_pending,
    input logic stall,
    input logic out_valid,
    input logic tos_clear,
    input logic tag_clear
);
    // R5
    accept_to_result_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);
    // R5
    idle_no_result_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> !out_valid);
    // R6
    reg_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && src_is_reg) |=> (tos_clear && tag_clear && out_valid));
    // R7
    mem_no_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !src_is_reg) |=> (!tos_clear && !tag_clear));
    // R8
    pending_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_is_reg && fp_exc_pending) |-> (stall && !in_ready));
    // R8
    stalled_no_result_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> !out_valid);
    // R9
    mem_never_waits_chk: assert property (@(posedge clk) disable iff (rst)
        !src_is_reg |-> (in_ready && !stall));
    // R6
    strobes_single_chk: assert property (@(posedge clk) disable iff (rst)
        tos_clear |=> (!tos_clear || $past(in_valid && in_ready && src_is_reg)));
endmodule

bind pkcvt_i2d pkcvt_i2d_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .src_is_reg     (src_is_reg),
    .fp_exc_pending (fp_exc_pending),
    .stall          (stall),
    .out_valid      (out_valid),
    .tos_clear      (tos_clear),
    .tag_clear      (tag_clear)
);

// File: tb/pkcvt_i2d_bench.sv
module pkcvt_i2d_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic         src_is_reg;
    logic [63:0]  reg_src;
    logic [63:0]  mem_src;
    logic         fp_exc_pending;
    logic         stall;
    logic         out_valid;
    logic [127:0] out_data;
    logic         tos_clear;
    logic         tag_clear;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pkcvt_i2d u_pkcvt_i2d (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .src_is_reg(src_is_reg), .reg_src(reg_src), .mem_src(mem_src),
        .fp_exc_pending(fp_exc_pending), .stall(stall), .out_valid(out_valid),
        .out_data(out_data), .tos_clear(tos_clear), .tag_clear(tag_clear)
    );

    function automatic logic [63:0] ref_dbl(input logic [31:0] v);
        real r;
        r = real'($signed(v));
        return $realtobits(r);
    endfunction

    function automatic logic [127:0] ref_pair(input logic [63:0] s);
        return {ref_dbl(s[63:32]), ref_dbl(s[31:0])};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one request that is expected to be accepted, then check the result cycle.
    task automatic run_op(input bit from_reg, input logic [63:0] rs,
                          input logic [63:0] ms, input bit pend, input string req);
        logic [127:0] exp_d;
        @(negedge clk);
        in_valid = 1'b1; src_is_reg = from_reg; reg_src = rs; mem_src = ms;
        fp_exc_pending = pend;
        exp_d = ref_pair(from_reg ? rs : ms);
        #1;
        chk(in_ready === 1'b1 && stall === 1'b0, "R9", "ready/stall at request",
            {126'd0, in_ready, stall}, 128'd2);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1, "R5", "out_valid", {127'd0, out_valid}, 128'd1);
        chk(out_data === exp_d, req, "result", out_data, exp_d);
        chk(tos_clear === from_reg && tag_clear === from_reg, from_reg ? "R6" : "R7",
            "strobes", {126'd0, tos_clear, tag_clear}, {126'd0, from_reg, from_reg});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] a;
        logic [63:0] b;
        void'($urandom(32'h1234_5678));
        rst = 1'b1; in_valid = 1'b0; src_is_reg = 1'b0; reg_src = '0; mem_src = '0;
        fp_exc_pending = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(out_valid === 1'b0 && out_data === '0 && tos_clear === 1'b0 && tag_clear === 1'b0,
            "R11", "reset state", out_data, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R5", "idle no result", {127'd0, out_valid}, 128'd0);

        // R3 zero lanes, R4 most negative, R2 lane order, R1 simple values
        run_op(1'b0, 64'd0, 64'd0, 1'b0, "R3");
        run_op(1'b0, 64'd0, 64'h8000_0000_0000_0000, 1'b0, "R4");
        chk(out_data[63:0] === 64'd0 && out_data[127:64] === 64'hC1E0_0000_0000_0000,
            "R4", "min int encoding", out_data, {64'hC1E0_0000_0000_0000, 64'd0});
        run_op(1'b1, 64'h8000_0000_8000_0000, 64'd7, 1'b0, "R4");
        run_op(1'b0, 64'h5, {32'hFFFF_FFFF, 32'd1}, 1'b0, "R2");
        chk(out_data[63:0] === 64'h3FF0_0000_0000_0000 &&
            out_data[127:64] === 64'hBFF0_0000_0000_0000,
            "R2", "lane placement", out_data,
            {64'hBFF0_0000_0000_0000, 64'h3FF0_0000_0000_0000});
        run_op(1'b1, {32'h7FFF_FFFF, 32'h4000_0000}, 64'd0, 1'b0, "R1");
        run_op(1'b1, {32'h8000_0001, 32'd3}, 64'd0, 1'b0, "R1");

        // R9 memory source ignores a pending exception
        run_op(1'b0, 64'd9, {32'd12345, 32'hFFFF_FF85}, 1'b1, "R9");

        // R8 stall, R10 held request completes after pending clears
        @(negedge clk);
        in_valid = 1'b1; src_is_reg = 1'b1; reg_src = {32'hFFFF_0000, 32'd1000};
        mem_src = 64'd0; fp_exc_pending = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(stall === 1'b1 && in_ready === 1'b0, "R8", "stall asserted",
                {126'd0, stall, in_ready}, 128'd2);
            @(negedge clk);
            chk(out_valid === 1'b0 && tos_clear === 1'b0, "R8", "no result while stalled",
                {126'd0, out_valid, tos_clear}, 128'd0);
        end
        fp_exc_pending = 1'b0;
        #1;
        chk(stall === 1'b0 && in_ready === 1'b1, "R10", "released",
            {126'd0, stall, in_ready}, 128'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1 && out_data === ref_pair({32'hFFFF_0000, 32'd1000}),
            "R10", "held result", out_data, ref_pair({32'hFFFF_0000, 32'd1000}));
        chk(tos_clear === 1'b1 && tag_clear === 1'b1, "R6", "held strobes",
            {126'd0, tos_clear, tag_clear}, 128'd3);
        @(negedge clk);
        chk(out_valid === 1'b0 && tos_clear === 1'b0 && tag_clear === 1'b0, "R6",
            "strobes one cycle", {126'd0, out_valid, tos_clear}, 128'd0);

        // R1 random powers of two and random values
        for (int i = 0; i < 31; i++) begin
            a = {32'd1 << i, -(32'd1 << i)};
            run_op(1'b0, 64'd0, a, 1'b0, "R1");
        end
        for (int i = 0; i < 200; i++) begin
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if ($urandom % 8 == 0) a[31:0] = 32'd0;
            run_op(1'($urandom % 2), a, b, 1'b0, "R1");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule